// File: doc/BRIEF.md
# Single-Byte Serial Peripheral Master

This block is a memory-mapped SPI master that moves exactly one 8-bit word per transfer. It has no queue. Software sets the serial mode and the clock divisor, places a byte in the transmit register and writes the start bit. The block then drives the serial clock and the outgoing data line, and samples the incoming line. When the byte is complete, it raises an interrupt. Software reads the received byte, which clears the interrupt. For the next byte, software loads the transmit register and writes start again.

The register window is byte wide and is reached through a simple synchronous write strobe and a combinational read port with a read strobe. Clock polarity, latching phase, bit order and an internal loopback of the outgoing line onto the incoming line are all set from the mode register. Chip select lies outside the block.

Top module: `spi_byte_master`

## Requirements
- R1: The registers sit at these offsets: mode 0, receive data 1, transmit data 2, control 3, status 4, clock divisor 6. Offsets 3 and 5 read as zero. After reset, every register reads zero, the interrupt is low and the serial clock is low.
- R2: When the port is enabled (mode bit 0x08) and idle, writing a value with bit 0x01 set to control starts a transfer of the byte held in the transmit register. Status bit 0x02 (busy) reads 1 during the transfer.
- R3: Each serial clock period lasts 4*(D+1) bus clocks, where D is the divisor (0..255). A transfer has 16 serial clock edges. The interrupt first shows 32*(D+1)+1 bus-clock negedges after the start write is taken.
- R4: Mode bit 0x02 sets the idle level of the serial clock. The clock rests at that level whenever no transfer is active.
- R5: When mode bit 0x10 is 1, data is latched on the leading clock edges. When it is 0, data is latched on the trailing edges. In both cases each outgoing bit is stable on the line at the latching edge.
- R6: Mode bit 0x04 selects LSB-first order. When it is clear, the order is MSB-first. The order applies to both the outgoing bits and the assembled received byte.
- R7: When mode bit 0x01 is set, the incoming line is ignored and the received byte equals the transmitted byte.
- R8: At completion, the receive register is loaded and status bit 0x01 (ready) and the interrupt rise on the same clock edge. Busy falls exactly one clock later.
- R9: A read of the receive register clears ready and the interrupt.
- R10: A start write while busy is ignored. The transfer in progress keeps its timing and data, and no second transfer follows.
- R11: When the enable bit is clear, a start write starts nothing and the clock stays at its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| re_i | input | 1 | Register read strobe (read side effects) |
| addr_i | input | 3 | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| irq_o | output | 1 | Byte-complete interrupt |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
The bench acts as a serial slave that follows the edges of the serial clock. It presents its own byte in the selected order and captures the outgoing bits on the latching edges. This separates the four polarity and phase combinations and the two bit orders. A fault in either direction shows as a mismatched byte. Loopback transfers use a slave byte that differs from the transmit byte, so an ignored loopback bit is visible. Divisor values from 0 to 255 show prescaler errors as a shifted interrupt cycle. A start write in the middle of a transfer and a start write while disabled show whether the gating is correct.

// File: rtl/spi_byte_pkg.sv
`timescale 1ns/1ps
package spi_byte_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned DIV_W  = 8;

  localparam logic [ADDR_W-1:0] OFF_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] OFF_RXD  = 3'd1;
  localparam logic [ADDR_W-1:0] OFF_TXD  = 3'd2;
  localparam logic [ADDR_W-1:0] OFF_CTRL = 3'd3;
  localparam logic [ADDR_W-1:0] OFF_STAT = 3'd4;
  localparam logic [ADDR_W-1:0] OFF_DIV  = 3'd6;

  // field order follows the mode register bit positions 4..0
  typedef struct packed {
    logic lead;   // latch on leading edge
    logic en;
    logic lsb;
    logic cpol;
    logic loop;
  } mode_t;

  localparam int unsigned MODE_W = $bits(mode_t);
endpackage

// File: rtl/spi_byte_regs.sv
`timescale 1ns/1ps
module spi_byte_regs
  import spi_byte_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned VW = DIV_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [DW-1:0]     rx_byte_i,
  output mode_t             mode_o,
  output logic [VW-1:0]     div_o,
  output logic [DW-1:0]     txd_o,
  output logic              start_o,
  output logic              rx_ready_o
);
  mode_t         mode_q;
  logic [VW-1:0] div_q;
  logic [DW-1:0] txd_q, rxd_q;
  logic          ready_q;
  logic          rd_rx;

  assign rd_rx   = re_i && (addr_i == OFF_RXD);
  assign start_o = we_i && (addr_i == OFF_CTRL) && wdata_i[0] && mode_q.en && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      div_q   <= '0;
      txd_q   <= '0;
      rxd_q   <= '0;
      ready_q <= 1'b0;
    end else begin
      if (we_i) begin
        unique case (addr_i)
          OFF_MODE: mode_q <= mode_t'(wdata_i[MODE_W-1:0]);
          OFF_TXD:  txd_q  <= wdata_i;
          OFF_DIV:  div_q  <= wdata_i[VW-1:0];
          default: ;
        endcase
      end
      if (done_i) begin
        rxd_q   <= rx_byte_i;
        ready_q <= 1'b1;
      end else if (rd_rx) begin
        ready_q <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFF_MODE: rdata_o = DW'(mode_q);
      OFF_RXD:  rdata_o = rxd_q;
      OFF_TXD:  rdata_o = txd_q;
      OFF_STAT: rdata_o = DW'({busy_i, ready_q});
      OFF_DIV:  rdata_o = DW'(div_q);
      default:  rdata_o = '0;
    endcase
  end

  assign mode_o     = mode_q;
  assign div_o      = div_q;
  assign txd_o      = txd_q;
  assign rx_ready_o = ready_q;
endmodule

// File: rtl/spi_byte_prescaler.sv
`timescale 1ns/1ps
module spi_byte_prescaler #(
  parameter int unsigned VW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [VW-1:0] div_i,
  output logic          tick_o
);
  // one tick per half serial period: 2*(div+1) bus clocks
  logic [VW:0] cnt_q;
  logic [VW:0] last_c;

  assign last_c = {div_i, 1'b1};
  assign tick_o = run_i && (cnt_q == last_c);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_byte_shifter.sv
`timescale 1ns/1ps
module spi_byte_shifter #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          tick_i,
  input  logic [DW-1:0] tx_byte_i,
  input  logic          lead_i,
  input  logic          lsb_i,
  input  logic          cpol_i,
  input  logic          loop_i,
  input  logic          miso_i,
  output logic          busy_o,
  output logic          run_o,
  output logic          done_o,
  output logic [DW-1:0] rx_byte_o,
  output logic          sck_o,
  output logic          mosi_o
);
  localparam int unsigned EDGES = 2 * DW;
  localparam int unsigned CW    = $clog2(EDGES);

  logic          active_q, tail_q, ph_q;
  logic [CW-1:0] edge_q;
  logic [DW-1:0] tx_q, rx_q, rx_nxt;
  logic          step, leading, last, sample, shift, din;

  assign step    = tick_i && active_q;
  assign leading = !edge_q[0];
  assign last    = edge_q == CW'(EDGES - 1);
  assign sample  = step && (lead_i ? leading : !leading);
  // shift after each sample except the final one
  assign shift   = step && !sample && !(lead_i ? last : (edge_q == '0));

  assign mosi_o  = lsb_i ? tx_q[0] : tx_q[DW-1];
  assign din     = loop_i ? mosi_o : miso_i;

  always_comb begin
    rx_nxt = rx_q;
    if (sample) rx_nxt = lsb_i ? {din, rx_q[DW-1:1]} : {rx_q[DW-2:0], din};
  end

  assign done_o    = step && last;
  assign rx_byte_o = rx_nxt;
  assign busy_o    = active_q || tail_q;
  assign run_o     = active_q;
  assign sck_o     = ph_q ^ cpol_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      tail_q   <= 1'b0;
      ph_q     <= 1'b0;
      edge_q   <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
    end else begin
      tail_q <= 1'b0;
      rx_q   <= rx_nxt;
      if (start_i) begin
        active_q <= 1'b1;
        ph_q     <= 1'b0;
        edge_q   <= '0;
        tx_q     <= tx_byte_i;
      end else if (step) begin
        ph_q   <= ~ph_q;
        edge_q <= edge_q + 1'b1;
        if (shift) tx_q <= lsb_i ? (tx_q >> 1) : (tx_q << 1);
        if (last) begin
          active_q <= 1'b0;
          tail_q   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_byte_master.sv
`timescale 1ns/1ps
module spi_byte_master
  import spi_byte_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i
);
  mode_t             mode;
  logic [DIV_W-1:0]  div;
  logic [DATA_W-1:0] txd, rx_byte;
  logic              start, busy, run, done, tick, rx_ready;
  logic              pol_idle, port_en;

  spi_byte_regs #(.DW(DATA_W), .VW(DIV_W)) u_regs (
    .clk_i, .rst_ni, .we_i, .re_i, .addr_i, .wdata_i, .rdata_o,
    .busy_i(busy), .done_i(done), .rx_byte_i(rx_byte),
    .mode_o(mode), .div_o(div), .txd_o(txd), .start_o(start),
    .rx_ready_o(rx_ready)
  );

  spi_byte_prescaler #(.VW(DIV_W)) u_pre (
    .clk_i, .rst_ni, .run_i(run), .div_i(div), .tick_o(tick)
  );

  spi_byte_shifter #(.DW(DATA_W)) u_shift (
    .clk_i, .rst_ni, .start_i(start), .tick_i(tick), .tx_byte_i(txd),
    .lead_i(mode.lead), .lsb_i(mode.lsb), .cpol_i(mode.cpol),
    .loop_i(mode.loop), .miso_i, .busy_o(busy), .run_o(run),
    .done_o(done), .rx_byte_o(rx_byte), .sck_o, .mosi_o
  );

  assign irq_o    = rx_ready;
  assign pol_idle = mode.cpol;
  assign port_en  = mode.en;
endmodule

// File: rtl/spi_byte_master_chk.sv
`timescale 1ns/1ps
module spi_byte_master_chk
  import spi_byte_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              re_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              irq_o,
  input logic              sck_o,
  input logic              busy,
  input logic              done,
  input logic              pol_idle,
  input logic              port_en
);
  AST_SCK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> sck_o == pol_idle); // R4
  AST_IRQ_FROM_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(done)); // R8
  AST_BUSY_AT_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> busy); // R8
  AST_BUSY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |=> !busy); // R8
  AST_RD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i == OFF_RXD && !done) |=> !irq_o); // R9
  AST_NO_START_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_en |=> !$rose(busy)); // R11
endmodule

bind spi_byte_master spi_byte_master_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .re_i(re_i), .addr_i(addr_i),
  .irq_o(irq_o), .sck_o(sck_o), .busy(busy), .done(done),
  .pol_idle(pol_idle), .port_en(port_en)
);

// File: tb/spi_byte_master_tb.sv
`timescale 1ns/1ps
module spi_byte_master_tb;
  logic       clk = 1'b0, rst_n = 1'b0, we = 1'b0, re = 1'b0, miso = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  wire  [7:0] rdata;
  wire        irq, sck, mosi;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  spi_byte_master u_dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .re_i(re), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .sck_o(sck),
    .mosi_o(mosi), .miso_i(miso)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; re = 1'b1;
    #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  function automatic int exp_irq_cyc(input int div);
    return 32 * (div + 1) + 1;
  endfunction

  function automatic logic [7:0] mode_val(input bit lead, input bit en,
      input bit lsb, input bit cpol, input bit loop);
    return {3'b000, lead, en, lsb, cpol, loop};
  endfunction

  function automatic logic bit_at(input logic [7:0] b, input bit lsb, input int k);
    return lsb ? b[k] : b[7-k];
  endfunction

  task automatic xfer(input bit lead, input bit lsb, input bit cpol, input bit loop,
                      input int div, input logic [7:0] txb, input logic [7:0] slvb,
                      input bit mid_start);
    logic [7:0] got, r;
    logic       prev;
    int cyc, irq_cyc, edges, nlat, nsh, idx;
    bit seen;
    wr(3'd6, 8'(div));
    wr(3'd0, mode_val(lead, 1'b1, lsb, cpol, loop));
    wr(3'd2, txb);
    miso = bit_at(slvb, lsb, 0);
    check("R4", "idle sck before start", 32'(sck), 32'(cpol));
    @(negedge clk); addr = 3'd3; wdata = 8'h01; we = 1'b1;
    @(negedge clk); we = 1'b0; addr = 3'd4;
    cyc = 1; seen = 0; irq_cyc = 0; edges = 0; nlat = 0; nsh = 0; got = '0;
    prev = sck;
    #1 check("R2", "busy after start", 32'(rdata[1]), 32'd1);
    while (cyc < exp_irq_cyc(div) + 12 && !(seen && cyc >= irq_cyc + 3)) begin
      if (sck !== prev) begin
        edges++;
        if ((lead && (sck != cpol)) || (!lead && (sck == cpol))) begin
          if (nlat < 8) got[lsb ? nlat : 7 - nlat] = mosi;
          nlat++;
        end else begin
          nsh++;
          idx = lead ? nsh : nsh - 1;
          if (idx < 8) miso = bit_at(slvb, lsb, idx);
        end
        prev = sck;
      end
      if (addr == 3'd4) begin
        if (irq && !seen) begin
          seen = 1; irq_cyc = cyc;
          check("R8", "busy still set with irq", 32'(rdata[1]), 32'd1);
          check("R8", "ready with irq", 32'(rdata[0]), 32'd1);
        end else if (seen && cyc == irq_cyc + 1) begin
          check("R8", "busy one clock after irq", 32'(rdata[1]), 32'd0);
        end
      end
      @(negedge clk); cyc++;
      if (mid_start && cyc == 5) begin addr = 3'd3; wdata = 8'h01; we = 1'b1; end
      if (mid_start && cyc == 6) begin we = 1'b0; addr = 3'd4; end
    end
    check(mid_start ? "R10" : "R3", "irq cycle", 32'(irq_cyc), 32'(exp_irq_cyc(div)));
    check("R3", "sck edge count", 32'(edges), 32'd16);
    check("R5", "bits seen by slave", 32'(got), 32'(txb));
    check("R4", "idle sck after", 32'(sck), 32'(cpol));
    rd(3'd1, r);
    check(loop ? "R7" : "R6", "received byte", 32'(r), 32'(loop ? txb : slvb));
    check("R9", "irq after rx read", 32'(irq), 32'd0);
    rd(3'd4, r);
    check(mid_start ? "R10" : "R9", "status after read", 32'(r), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL R2 watchdog expired: got running expected finished");
    $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail + 1);
    $finish;
  end

  initial begin
    logic [7:0] r;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1", "irq at reset", 32'(irq), 32'd0);
    check("R1", "sck at reset", 32'(sck), 32'd0);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), r);
      check("R1", $sformatf("reset read offset %0d", a), 32'(r), 32'd0);
    end
    // R1 readback
    wr(3'd6, 8'hA5); rd(3'd6, r); check("R1", "divisor readback", 32'(r), 32'hA5);
    wr(3'd2, 8'h5A); rd(3'd2, r); check("R1", "tx readback", 32'(r), 32'h5A);
    wr(3'd0, 8'h17); rd(3'd0, r); check("R1", "mode readback", 32'(r), 32'h17);
    wr(3'd3, 8'hFE); rd(3'd3, r); check("R1", "control reads zero", 32'(r), 32'd0);
    // R11 disabled port: cpol=1, enable clear
    wr(3'd0, mode_val(1'b1, 1'b0, 1'b0, 1'b1, 1'b0));
    wr(3'd3, 8'h01);
    repeat (20) @(negedge clk);
    rd(3'd4, r);
    check("R11", "status while disabled", 32'(r), 32'd0);
    check("R11", "sck idle while disabled", 32'(sck), 32'd1);
    // directed
    xfer(1, 0, 0, 0, 0,   8'hA5, 8'h3C, 0);   // R5 leading latch, MSB first
    xfer(0, 0, 0, 0, 1,   8'hC3, 8'h96, 0);   // R5 trailing latch
    xfer(1, 1, 1, 0, 2,   8'h81, 8'h7E, 0);   // R6 LSB first, R4 idle high
    xfer(0, 1, 1, 0, 0,   8'h12, 8'hF0, 0);   // R6
    xfer(1, 0, 0, 1, 0,   8'h6B, 8'h00, 0);   // R7 loopback
    xfer(0, 1, 1, 1, 3,   8'hD4, 8'hFF, 0);   // R7
    xfer(1, 0, 0, 0, 1,   8'h55, 8'hAA, 1);   // R10 start while busy
    xfer(0, 0, 1, 0, 255, 8'hE7, 8'h18, 0);   // R3 largest divisor
    // random mix
    for (int i = 0; i < 12; i++) begin
      int v;
      v = $urandom;
      xfer(v[0], v[1], v[2], v[3], $urandom % 4, 8'($urandom), 8'($urandom), 0);
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule